// File: doc/BRIEF.md
# Push-All Register Sequencer

This block executes the legacy "push all general-purpose registers" instruction inside a CPU core as a multi-cycle micro-sequence. A command arrives on a valid/ready start channel carrying the opcode byte, the operand size (16 or 32 bits), the mode flags (64-bit, real-address, virtual-8086), a LOCK-prefix flag and the current stack pointer. The block accepts a new command only when it is idle and not shut down. Back-pressure on the start channel therefore lasts for the whole instruction.

Before any memory traffic, the block screens the command for faults. If the command passes, the block reads the eight general registers one at a time through a combinational register-file read port. It stores each one on a valid/ready memory write channel. The memory side may hold `mem_ready` low for any number of cycles. While it does, the block keeps address, data and byte enables frozen. A beat completes only on a cycle where both valid and ready are high. After the eighth beat completes, the new stack pointer is written back in a single cycle that also reports completion.

A faulting command produces a one-cycle fault pulse with a code and leaves memory and the stack pointer untouched. A shutdown condition parks the block with `shutdown` high until reset.

Top module: `pushall_seq`

## Requirements
- R1: Register-file index k (0 AX, 1 CX, 2 DX, 3 BX, 4 SP, 5 BP, 6 SI, 7 DI) is stored as the k-th write. The fifth write (k = 4) carries the stack pointer captured when the command was accepted, not a decremented value.
- R2: Write k goes to address SP0 − (k+1)·S, where S is 2 for a 16-bit operand size and 4 for a 32-bit one. In 16-bit size the address wraps modulo 2^16 and its upper 16 bits are zero.
- R3: In 16-bit size `mem_be` is 4'b0011 and `mem_data` holds the low 16 bits of the value, zero-extended. In 32-bit size `mem_be` is 4'b1111 and the full value is written.
- R4: The cycle after the eighth accepted write, `done` and `sp_we` are high for one cycle. `sp_wdata` is SP0 − 32 in 32-bit size. In 16-bit size it is SP0 with only its low 16 bits reduced by 16 (modulo 2^16).
- R5: An opcode other than 8'h60 gives a fault with `fault_code` 3 and no writes.
- R6: With the 64-bit mode flag set, the block gives a fault with `fault_code` 1 (invalid opcode). It makes no writes and does not write the stack pointer.
- R7: A LOCK prefix gives `fault_code` 1 in every mode.
- R8: In real-address or virtual-8086 mode, a stack pointer of 7, 9, 11, 13 or 15 gives a fault with `fault_code` 2 (general protection). The value compared is the low 16 bits in 16-bit size and the full value in 32-bit size.
- R9: In real-address mode only, a stack pointer of 1, 3 or 5 (compared as in R8) raises `shutdown`. It stays high with `start_ready` low and no writes until reset. In virtual-8086 mode these values execute normally.
- R10: While `mem_valid` is high and `mem_ready` is low, the next cycle keeps `mem_valid` high with `mem_addr`, `mem_data` and `mem_be` unchanged.
- R11: `start_ready` is high only when the block is idle. A command is taken on a cycle with both `start_valid` and `start_ready` high. Exactly one of `done`, `fault` or `shutdown` ends each command.
- R12: Checks are ranked, highest first: opcode mismatch (code 3), then 64-bit mode or LOCK (code 1), then general protection (code 2), then shutdown.
- R13: After reset, `start_ready` is high and `mem_valid`, `done`, `fault` and `shutdown` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Command offered |
| start_ready | output | 1 | Block idle and can take a command |
| cmd_opcode | input | 8 | Opcode byte |
| cmd_op32 | input | 1 | 1: 32-bit operand size, 0: 16-bit |
| cmd_mode64 | input | 1 | Core is in 64-bit mode |
| cmd_real | input | 1 | Core is in real-address mode |
| cmd_v86 | input | 1 | Core is in virtual-8086 mode |
| cmd_lock | input | 1 | LOCK prefix present |
| sp_in | input | DATA_W | Stack pointer at command time |
| rf_rd_idx | output | IDX_W | Register-file read index |
| rf_rd_data | input | DATA_W | Register-file read data (combinational) |
| mem_valid | output | 1 | Write beat offered |
| mem_ready | input | 1 | Memory takes the beat |
| mem_addr | output | DATA_W | Byte address of the beat |
| mem_data | output | DATA_W | Write data, right-aligned |
| mem_be | output | DATA_W/8 | Byte-lane enables |
| sp_we | output | 1 | Stack-pointer write strobe |
| sp_wdata | output | DATA_W | New stack pointer |
| done | output | 1 | Command completed |
| fault | output | 1 | Command faulted |
| fault_code | output | 2 | 1 invalid opcode, 2 general protection, 3 opcode mismatch; 0 when no fault |
| shutdown | output | 1 | Block halted until reset |

## Verification
The bench aims at the fifth slot, which must carry the captured stack pointer. A design that pushed the live or decremented value would put a number 2 to 16 lower at address SP0 − 5·S. It also sweeps small stack pointers across every mode, so that a GP check keyed only to the low bits, or a shutdown raised in virtual-8086 mode, shows up as a wrong outcome. A 16-bit run near address zero exposes a carry that leaks into the upper address bits or into the kept upper half of the new stack pointer. Random stalls on `mem_ready` expose any beat that advances, or any address that changes, before it has been taken.

// File: rtl/pushall_pkg.sv
package pushall_pkg;

  typedef enum logic [1:0] {
    FC_NONE    = 2'd0,
    FC_UD      = 2'd1,
    FC_GP      = 2'd2,
    FC_NOMATCH = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    VD_PASS,
    VD_FAULT,
    VD_HALT
  } verdict_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_LOAD,
    ST_WRITE,
    ST_COMMIT,
    ST_FAULT,
    ST_HALT
  } state_e;

  typedef struct packed {
    logic [7:0] opcode;
    logic       op32;
    logic       mode64;
    logic       real_m;
    logic       v86;
    logic       lock;
  } cmd_t;

endpackage

// File: rtl/pushall_precheck.sv
module pushall_precheck
  import pushall_pkg::*;
#(
  parameter int         DATA_W = 32,
  parameter logic [7:0] OPCODE = 8'h60
) (
  input  cmd_t              cmd,
  input  logic [DATA_W-1:0] sp,
  output verdict_e          verdict,
  output fault_e            code
);

  logic [DATA_W-1:0] sp_eff;
  logic              gp_hit;
  logic              halt_hit;

  // effective pointer: 16-bit operand size looks at the low half only
  assign sp_eff = cmd.op32 ? sp : {{(DATA_W-16){1'b0}}, sp[15:0]};

  always_comb begin
    gp_hit = 1'b0;
    for (int v = 7; v <= 15; v += 2) begin
      if (sp_eff == DATA_W'(v)) gp_hit = 1'b1;
    end
    halt_hit = 1'b0;
    for (int v = 1; v <= 5; v += 2) begin
      if (sp_eff == DATA_W'(v)) halt_hit = 1'b1;
    end
  end

  // ranked screening, highest first
  always_comb begin
    verdict = VD_PASS;
    code    = FC_NONE;
    if (cmd.opcode != OPCODE) begin
      verdict = VD_FAULT;
      code    = FC_NOMATCH;
    end else if (cmd.mode64 || cmd.lock) begin
      verdict = VD_FAULT;
      code    = FC_UD;
    end else if ((cmd.real_m || cmd.v86) && gp_hit) begin
      verdict = VD_FAULT;
      code    = FC_GP;
    end else if (cmd.real_m && halt_hit) begin
      verdict = VD_HALT;
      code    = FC_NONE;
    end
  end

endmodule

// File: rtl/pushall_addr.sv
module pushall_addr #(
  parameter  int DATA_W   = 32,
  parameter  int NUM_REGS = 8,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [DATA_W-1:0] sp0,
  input  logic              op32,
  input  logic [IDX_W-1:0]  slot,
  output logic [DATA_W-1:0] addr,
  output logic [DATA_W-1:0] sp_final
);

  localparam int HALF = 16;

  logic [DATA_W-1:0] step_off;
  logic [DATA_W-1:0] total_off;
  logic [HALF-1:0]   lo_addr;
  logic [HALF-1:0]   lo_final;

  // slot k sits (k+1) slots below the starting pointer
  assign step_off  = (DATA_W'(slot) + DATA_W'(1)) << (op32 ? 2 : 1);
  assign total_off = DATA_W'(NUM_REGS) << (op32 ? 2 : 1);

  assign lo_addr  = sp0[HALF-1:0] - step_off[HALF-1:0];
  assign lo_final = sp0[HALF-1:0] - total_off[HALF-1:0];

  assign addr     = op32 ? (sp0 - step_off)
                         : {{(DATA_W-HALF){1'b0}}, lo_addr};
  assign sp_final = op32 ? (sp0 - total_off)
                         : {sp0[DATA_W-1:HALF], lo_final};

endmodule

// File: rtl/pushall_wrport.sv
module pushall_wrport #(
  parameter  int DATA_W = 32,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              op32,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] addr_in,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [BE_W-1:0]   mem_be,
  output logic              accepted
);

  logic [BE_W-1:0] be_half;

  // lane mask for a 16-bit beat: the two lowest byte lanes
  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign be_half[b] = (b < 2);
  end

  assign accepted = mem_valid && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      mem_be    <= '0;
    end else if (load) begin
      mem_valid <= 1'b1;
      mem_addr  <= addr_in;
      mem_data  <= op32 ? data_in : {{(DATA_W-16){1'b0}}, data_in[15:0]};
      mem_be    <= op32 ? {BE_W{1'b1}} : be_half;
    end else if (accepted) begin
      mem_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/pushall_ctrl.sv
module pushall_ctrl
  import pushall_pkg::*;
#(
  parameter  int NUM_REGS = 8,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  output logic             capture,
  input  verdict_e         verdict,
  input  fault_e           verdict_code,
  output logic             load,
  input  logic             accepted,
  output logic [IDX_W-1:0] slot,
  output logic             done,
  output logic             fault,
  output fault_e           fault_code,
  output logic             shutdown
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

  state_e st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:   if (start_valid) st_nx = ST_CHECK;
      ST_CHECK: begin
        unique case (verdict)
          VD_FAULT: st_nx = ST_FAULT;
          VD_HALT:  st_nx = ST_HALT;
          default:  st_nx = ST_LOAD;
        endcase
      end
      ST_LOAD:   st_nx = ST_WRITE;
      ST_WRITE:  if (accepted) st_nx = (slot == LAST) ? ST_COMMIT : ST_LOAD;
      ST_COMMIT: st_nx = ST_IDLE;
      ST_FAULT:  st_nx = ST_IDLE;
      ST_HALT:   st_nx = ST_HALT;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      slot       <= '0;
      fault_code <= FC_NONE;
    end else begin
      st <= st_nx;
      if (st == ST_CHECK) begin
        fault_code <= verdict_code;
        slot       <= '0;
      end
      if (st == ST_WRITE && accepted && slot != LAST) slot <= slot + 1'b1;
    end
  end

  assign start_ready = (st == ST_IDLE);
  assign capture     = start_valid && start_ready;
  assign load        = (st == ST_LOAD);
  assign done        = (st == ST_COMMIT);
  assign fault       = (st == ST_FAULT);
  assign shutdown    = (st == ST_HALT);

endmodule

// File: rtl/pushall_seq.sv
module pushall_seq
  import pushall_pkg::*;
#(
  parameter  int         DATA_W   = 32,
  parameter  int         NUM_REGS = 8,
  parameter  int         SP_SLOT  = 4,
  parameter  logic [7:0] OPCODE   = 8'h60,
  localparam int         IDX_W    = $clog2(NUM_REGS),
  localparam int         BE_W     = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [7:0]        cmd_opcode,
  input  logic              cmd_op32,
  input  logic              cmd_mode64,
  input  logic              cmd_real,
  input  logic              cmd_v86,
  input  logic              cmd_lock,
  input  logic [DATA_W-1:0] sp_in,
  output logic [IDX_W-1:0]  rf_rd_idx,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [BE_W-1:0]   mem_be,
  output logic              sp_we,
  output logic [DATA_W-1:0] sp_wdata,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_code,
  output logic              shutdown
);

  cmd_t              cmd_q;
  logic [DATA_W-1:0] sp0_q;
  logic              capture;
  logic              load;
  logic              accepted;
  logic [IDX_W-1:0]  slot;
  verdict_e          verdict;
  fault_e            verdict_code;
  fault_e            fc_q;
  logic [DATA_W-1:0] slot_addr;
  logic [DATA_W-1:0] slot_data;

  // command and pointer snapshot taken at acceptance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      sp0_q <= '0;
    end else if (capture) begin
      cmd_q <= '{opcode: cmd_opcode, op32: cmd_op32, mode64: cmd_mode64,
                 real_m: cmd_real, v86: cmd_v86, lock: cmd_lock};
      sp0_q <= sp_in;
    end
  end

  pushall_precheck #(.DATA_W(DATA_W), .OPCODE(OPCODE)) u_check (
    .cmd     (cmd_q),
    .sp      (sp0_q),
    .verdict (verdict),
    .code    (verdict_code)
  );

  pushall_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_valid  (start_valid),
    .start_ready  (start_ready),
    .capture      (capture),
    .verdict      (verdict),
    .verdict_code (verdict_code),
    .load         (load),
    .accepted     (accepted),
    .slot         (slot),
    .done         (done),
    .fault        (fault),
    .fault_code   (fc_q),
    .shutdown     (shutdown)
  );

  pushall_addr #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_addr (
    .sp0      (sp0_q),
    .op32     (cmd_q.op32),
    .slot     (slot),
    .addr     (slot_addr),
    .sp_final (sp_wdata)
  );

  // the pointer slot carries the snapshot, every other slot the register file
  assign rf_rd_idx = slot;
  assign slot_data = (slot == IDX_W'(SP_SLOT)) ? sp0_q : rf_rd_data;

  pushall_wrport #(.DATA_W(DATA_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .op32      (cmd_q.op32),
    .data_in   (slot_data),
    .addr_in   (slot_addr),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .mem_be    (mem_be),
    .accepted  (accepted)
  );

  assign sp_we      = done;
  assign fault_code = fault ? fc_q : FC_NONE;

endmodule

// File: rtl/pushall_checker.sv
module pushall_checker #(
  parameter  int DATA_W = 32,
  localparam int BE_W   = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic              start_ready,
  input logic              cmd_op32,
  input logic [DATA_W-1:0] sp_in,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic [BE_W-1:0]   mem_be,
  input logic              sp_we,
  input logic [DATA_W-1:0] sp_wdata,
  input logic              done,
  input logic              fault,
  input logic              shutdown
);

  logic [DATA_W-1:0] snap_sp;
  logic              snap_op32;
  logic [4:0]        beats;
  logic [DATA_W-1:0] want_sp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_sp   <= '0;
      snap_op32 <= 1'b0;
      beats     <= '0;
    end else if (start_valid && start_ready) begin
      snap_sp   <= sp_in;
      snap_op32 <= cmd_op32;
      beats     <= '0;
    end else if (mem_valid && mem_ready) begin
      beats <= beats + 5'd1;
    end
  end

  assign want_sp = snap_op32 ? (snap_sp - DATA_W'(32))
                             : {snap_sp[DATA_W-1:16], snap_sp[15:0] - 16'd16};

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be));

  assert_eight_beats_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> beats == 5'd8 && sp_we);

  assert_new_sp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sp_wdata == want_sp);

  assert_fault_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> beats == 5'd0 && !sp_we && !mem_valid);

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> shutdown);

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> !start_ready && !mem_valid && !sp_we);

  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fault, shutdown}));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !mem_valid);

endmodule

bind pushall_seq pushall_checker #(.DATA_W(DATA_W)) u_pushall_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .cmd_op32    (cmd_op32),
  .sp_in       (sp_in),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .mem_addr    (mem_addr),
  .mem_data    (mem_data),
  .mem_be      (mem_be),
  .sp_we       (sp_we),
  .sp_wdata    (sp_wdata),
  .done        (done),
  .fault       (fault),
  .shutdown    (shutdown)
);

// File: tb/test_pushall_seq.sv
`timescale 1ns/1ps
module test_pushall_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [7:0]  cmd_opcode = 8'h60;
  logic        cmd_op32 = 1'b0;
  logic        cmd_mode64 = 1'b0;
  logic        cmd_real = 1'b0;
  logic        cmd_v86 = 1'b0;
  logic        cmd_lock = 1'b0;
  logic [31:0] sp_in = '0;
  logic [2:0]  rf_rd_idx;
  logic [31:0] rf_rd_data;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [31:0] mem_data;
  logic [3:0]  mem_be;
  logic        sp_we;
  logic [31:0] sp_wdata;
  logic        done;
  logic        fault;
  logic [1:0]  fault_code;
  logic        shutdown;

  logic [31:0] regs [8];
  logic        rdy_all = 1'b1;
  int          nw = 0;
  logic [31:0] la [1024];
  logic [31:0] ld [1024];
  logic [3:0]  lb [1024];
  int          errs = 0;
  int          checks = 0;

  always #2.5 clk = ~clk;

  assign rf_rd_data = regs[rf_rd_idx];

  pushall_seq i_pushall_seq (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .cmd_opcode(cmd_opcode), .cmd_op32(cmd_op32), .cmd_mode64(cmd_mode64),
    .cmd_real(cmd_real), .cmd_v86(cmd_v86), .cmd_lock(cmd_lock), .sp_in(sp_in),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .done(done), .fault(fault),
    .fault_code(fault_code), .shutdown(shutdown)
  );

  always @(negedge clk) mem_ready <= rdy_all ? 1'b1 : (($urandom % 3) != 0);

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (nw < 1024) begin
        la[nw] <= mem_addr;
        ld[nw] <= mem_data;
        lb[nw] <= mem_be;
      end
      nw <= nw + 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // 0 pass, 1 invalid opcode, 2 general protection, 3 mismatch, 4 shutdown
  function automatic int exp_outcome(input logic [7:0] opc, input bit o32, input bit m64,
                                     input bit rm, input bit v86, input bit lk, input logic [31:0] sp);
    logic [31:0] e;
    e = o32 ? sp : {16'h0, sp[15:0]};
    if (opc != 8'h60) return 3;
    if (m64 || lk) return 1;
    if ((rm || v86) && (e == 7 || e == 9 || e == 11 || e == 13 || e == 15)) return 2;
    if (rm && (e == 1 || e == 3 || e == 5)) return 4;
    return 0;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] sp, input bit o32, input int k);
    logic [15:0] lo;
    if (o32) return sp - 32'((k + 1) * 4);
    lo = sp[15:0] - 16'((k + 1) * 2);
    return {16'h0, lo};
  endfunction

  function automatic logic [31:0] exp_data(input logic [31:0] sp, input bit o32, input int k);
    logic [31:0] v;
    v = (k == 4) ? sp : regs[k];
    return o32 ? v : {16'h0, v[15:0]};
  endfunction

  function automatic logic [31:0] exp_final(input logic [31:0] sp, input bit o32);
    if (o32) return sp - 32'd32;
    return {sp[31:16], sp[15:0] - 16'd16};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_cmd(input logic [7:0] opc, input bit o32, input bit m64, input bit rm,
                         input bit v86, input bit lk, input logic [31:0] sp, input bit fast);
    int base;
    int cyc;
    int oc;
    rdy_all = fast;
    for (int r = 0; r < 8; r++) regs[r] = $urandom;
    @(negedge clk);
    cyc = 0;
    while (!start_ready && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    base = nw;
    cmd_opcode = opc; cmd_op32 = o32; cmd_mode64 = m64; cmd_real = rm;
    cmd_v86 = v86; cmd_lock = lk; sp_in = sp; start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    sp_in = $urandom;
    chk("R11", "start_ready while busy", 32'(start_ready), 32'd0);
    cyc = 0;
    while (!(done || fault || shutdown) && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    oc = exp_outcome(opc, o32, m64, rm, v86, lk, sp);
    if (cyc >= 400) begin
      chk("R11", "command never ended", 32'd1, 32'd0);
    end else if (oc == 0) begin
      chk("R4", "done", 32'(done), 32'd1);
      chk("R4", "sp_we", 32'(sp_we), 32'd1);
      chk("R4", "new stack pointer", sp_wdata, exp_final(sp, o32));
      chk("R4", "write count", 32'(nw - base), 32'd8);
      for (int k = 0; k < 8; k++) begin
        chk("R1", $sformatf("data slot %0d", k), ld[base + k], exp_data(sp, o32, k));
        chk("R2", $sformatf("addr slot %0d", k), la[base + k], exp_addr(sp, o32, k));
        chk("R3", $sformatf("be slot %0d", k), 32'(lb[base + k]), o32 ? 32'hF : 32'h3);
      end
    end else if (oc == 4) begin
      chk("R9", "shutdown", 32'(shutdown), 32'd1);
      repeat (5) @(negedge clk);
      chk("R9", "shutdown held", 32'(shutdown), 32'd1);
      chk("R9", "start_ready in shutdown", 32'(start_ready), 32'd0);
      chk("R9", "writes in shutdown", 32'(nw - base), 32'd0);
      do_reset();
      chk("R13", "start_ready after reset", 32'(start_ready), 32'd1);
    end else begin
      chk(oc == 3 ? "R5" : (oc == 1 ? "R6" : "R8"), "fault", 32'(fault), 32'd1);
      chk(oc == 3 ? "R5" : (oc == 1 ? "R7" : "R8"), "fault_code", 32'(fault_code), 32'(oc));
      chk("R6", "sp_we on fault", 32'(sp_we), 32'd0);
      chk("R6", "writes on fault", 32'(nw - base), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R11 watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < 8; r++) regs[r] = '0;
    do_reset();
    // R13 reset state
    chk("R13", "start_ready", 32'(start_ready), 32'd1);
    chk("R13", "mem_valid", 32'(mem_valid), 32'd0);
    chk("R13", "done", 32'(done), 32'd0);
    chk("R13", "fault", 32'(fault), 32'd0);
    chk("R13", "shutdown", 32'(shutdown), 32'd0);

    // R1 R2 R3 R4 plain runs, both widths
    run_cmd(8'h60, 1'b1, 0, 0, 0, 0, 32'h0001_0040, 1'b1);
    run_cmd(8'h60, 1'b0, 0, 0, 0, 0, 32'hABCD_0100, 1'b1);
    // R2 16-bit wrap near zero, upper half of pointer kept
    run_cmd(8'h60, 1'b0, 0, 0, 0, 0, 32'hABCD_0004, 1'b0);
    // R10 stalls with 32-bit beats
    run_cmd(8'h60, 1'b1, 0, 0, 0, 0, 32'h0000_0010, 1'b0);
    // R5 mismatch, R6 64-bit, R7 lock in real mode
    run_cmd(8'h61, 1'b1, 0, 0, 0, 0, 32'h0000_1000, 1'b1);
    run_cmd(8'h60, 1'b1, 1, 0, 0, 0, 32'h0000_1000, 1'b1);
    run_cmd(8'h60, 1'b0, 0, 1, 0, 1, 32'h0000_1000, 1'b1);
    // R8 GP in real and virtual-8086 mode
    run_cmd(8'h60, 1'b0, 0, 1, 0, 0, 32'h0000_0007, 1'b1);
    run_cmd(8'h60, 1'b0, 0, 0, 1, 0, 32'hFFFF_0009, 1'b1);
    // R9 shutdown in real mode, normal run in virtual-8086 mode
    run_cmd(8'h60, 1'b0, 0, 1, 0, 0, 32'h0000_0003, 1'b1);
    run_cmd(8'h60, 1'b0, 0, 0, 1, 0, 32'h0000_0003, 1'b0);
    // R12 ranking
    run_cmd(8'h60, 1'b0, 1, 1, 0, 0, 32'h0000_0007, 1'b1);
    run_cmd(8'h5F, 1'b0, 0, 1, 0, 1, 32'h0000_0003, 1'b1);
    run_cmd(8'h60, 1'b0, 0, 1, 0, 0, 32'h0001_0005, 1'b1);

    // R12 random mix
    for (int i = 0; i < 60; i++) begin
      int mode;
      logic [31:0] sp;
      mode = $urandom % 4;
      sp = (($urandom % 3) == 0) ? ($urandom % 16) : $urandom;
      run_cmd((($urandom % 10) == 0) ? 8'($urandom) : 8'h60, 1'($urandom),
              mode == 1, mode == 2, mode == 3, (($urandom % 8) == 0), sp, 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule